// File: doc/BRIEF.md
# Serial Identifier CRC-8 Checker

This block runs an 8-bit cyclic redundancy check over a serial bit stream that arrives one bit per strobe, least significant bit first. It serves a single-wire style slave in two ways. In identifier mode it takes a 64-bit identifier. It forms the CRC of the first 56 bits and compares that CRC with the final 8 bits, which carry the stored check byte. It then reports the result. In stream mode it folds every command, address and data bit into a running CRC. After each completed byte it presents that running value, and a byte count, for the transaction logic to send back to the master.

The result is advisory. The block has no ready or stall output, and a mismatch changes nothing except the status flags. Any decision to stop is left to the master. A start pulse clears the CRC and the counters and latches the mode. Line timing and command decoding are handled elsewhere.

Top module: `sidc_crc8_chk`

## Requirements
- R1: While reset is held, and in the cycle after a start pulse, the CRC output and the byte count are 0 and every flag is low. A bit strobed in the same cycle as start is discarded.
- R2: Each accepted bit updates the CRC in reflected form for the polynomial x^8+x^5+x^4+1. The feedback is crc[0] XOR bit. The register shifts right, and when the feedback is 1 it is XORed with 0x8C. Starting from 0, the single byte 0x01 sent LSB first gives 0x5E.
- R3: The mode input is sampled only on start (0 = identifier, 1 = stream). A later change has no effect, and a stream run never raises the identifier done flag.
- R4: In identifier mode the done flag rises in the cycle after the 64th accepted bit. It stays high until the next start.
- R5: The match flag is set with done, high exactly when the CRC of bits 0..55 equals bits 56..63 taken LSB first (bit 56 is the LSB of the stored byte). A mismatch only lowers this flag; done still rises.
- R6: The zero flag is set with done, high exactly when the CRC over all 64 bits is 0x00. It always agrees with the match flag.
- R7: In identifier mode, bits strobed after the 64th change neither the CRC output nor the count nor the flags.
- R8: The CRC output always shows the CRC over all bits accepted since start, so a well-formed identifier leaves 0x00.
- R9: In both modes a one-cycle byte-done pulse follows each 8th accepted bit. The byte count rises by one with the pulse and wraps modulo 2^BYTE_CNT_W.
- R10: The CRC output changes only in the cycle after an accepted bit or a start. Idle cycles hold it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Clears the CRC and counters and latches the mode |
| mode_i | input | 1 | 0 = identifier check, 1 = running stream CRC |
| bit_vld_i | input | 1 | Strobe: bit_i is valid this cycle |
| bit_i | input | 1 | Serial data bit, LSB first |
| crc_o | output | 8 | Running CRC |
| byte_done_o | output | 1 | One-cycle pulse after each completed byte |
| byte_cnt_o | output | BYTE_CNT_W | Completed bytes since start |
| id_done_o | output | 1 | Identifier fully received |
| id_match_o | output | 1 | Payload CRC equals the stored byte |
| id_zero_o | output | 1 | CRC over all identifier bits is zero |

## Verification
The bench keeps ID_BITS at 64, because the 56/8 split of the identifier is the behaviour under test. It narrows BYTE_CNT_W to 4, so the byte counter wraps after 16 bytes and a short stream run covers the wrap. Identifier frames are built from a CRC the bench computes itself, then corrupted in the payload and in the stored byte. The bench also drives bits back to back, with gaps, past the 64th bit, and in the same cycle as start.

// File: rtl/sidc_pkg.sv
package sidc_pkg;
  localparam int CRC_W = 8;

  typedef enum logic {
    MODE_ID     = 1'b0,
    MODE_STREAM = 1'b1
  } sidc_mode_e;

  // one reflected CRC step for a single input bit
  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] cur,
                                                input logic             din,
                                                input logic [CRC_W-1:0] poly);
    logic fb;
    fb = cur[0] ^ din;
    return (cur >> 1) ^ (fb ? poly : '0);
  endfunction

  // stored byte assembled LSB first compared against the payload CRC
  function automatic logic tail_ok(input logic [CRC_W-1:0] pay_crc,
                                   input logic [CRC_W-1:0] stored);
    return pay_crc == stored;
  endfunction
endpackage

// File: rtl/sidc_crc_reg.sv
module sidc_crc_reg
  import sidc_pkg::*;
#(
  parameter logic [CRC_W-1:0] POLY = 8'h8C
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             shift,
  input  logic             din,
  output logic [CRC_W-1:0] crc_q,
  output logic [CRC_W-1:0] crc_nxt
);
  always_comb crc_nxt = crc_step(crc_q, din, POLY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc_q <= '0;
    else if (clr)   crc_q <= '0;
    else if (shift) crc_q <= crc_nxt;
  end
endmodule

// File: rtl/sidc_bit_count.sv
module sidc_bit_count
  import sidc_pkg::*;
#(
  parameter int ID_BITS = 64,
  parameter int CNT_W   = 8,
  localparam int TOT_W  = $clog2(ID_BITS + 1),
  localparam int POS_W  = $clog2(CRC_W)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  output logic [TOT_W-1:0] bit_total,
  output logic             byte_end,
  output logic             byte_done_q,
  output logic [CNT_W-1:0] byte_cnt_q
);
  logic [POS_W-1:0] pos_q;
  logic             total_full;

  assign byte_end   = take && (pos_q == POS_W'(CRC_W - 1));
  assign total_full = (bit_total == TOT_W'(ID_BITS));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q       <= '0;
      bit_total   <= '0;
      byte_done_q <= 1'b0;
      byte_cnt_q  <= '0;
    end else if (clr) begin
      pos_q       <= '0;
      bit_total   <= '0;
      byte_done_q <= 1'b0;
      byte_cnt_q  <= '0;
    end else begin
      byte_done_q <= byte_end;
      if (take)                pos_q      <= pos_q + 1'b1;
      if (take && !total_full) bit_total  <= bit_total + 1'b1;
      if (byte_end)            byte_cnt_q <= byte_cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/sidc_id_cmp.sv
module sidc_id_cmp
  import sidc_pkg::*;
#(
  parameter int ID_BITS = 64,
  localparam int TOT_W    = $clog2(ID_BITS + 1),
  localparam int PAY_BITS = ID_BITS - CRC_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             take,
  input  logic             din,
  input  logic [CRC_W-1:0] crc_nxt,
  input  logic [TOT_W-1:0] bit_total,
  output logic             last_pay,
  output logic             last_id,
  output logic             id_done_q,
  output logic             id_match_q,
  output logic             id_zero_q
);
  logic [CRC_W-1:0] pay_crc_q;
  logic [CRC_W-1:0] stored_q;
  logic [CRC_W-1:0] stored_nxt;
  logic             in_tail;

  assign last_pay   = take && (bit_total == TOT_W'(PAY_BITS - 1));
  assign last_id    = take && (bit_total == TOT_W'(ID_BITS - 1));
  assign in_tail    = take && (bit_total >= TOT_W'(PAY_BITS));
  assign stored_nxt = {din, stored_q[CRC_W-1:1]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pay_crc_q  <= '0;
      stored_q   <= '0;
      id_done_q  <= 1'b0;
      id_match_q <= 1'b0;
      id_zero_q  <= 1'b0;
    end else if (clr) begin
      pay_crc_q  <= '0;
      stored_q   <= '0;
      id_done_q  <= 1'b0;
      id_match_q <= 1'b0;
      id_zero_q  <= 1'b0;
    end else begin
      if (last_pay) pay_crc_q <= crc_nxt;
      if (in_tail)  stored_q  <= stored_nxt;
      if (last_id) begin
        id_done_q  <= 1'b1;
        id_match_q <= tail_ok(pay_crc_q, stored_nxt);
        id_zero_q  <= (crc_nxt == '0);
      end
    end
  end
endmodule

// File: rtl/sidc_crc8_chk.sv
module sidc_crc8_chk
  import sidc_pkg::*;
#(
  parameter int               ID_BITS    = 64,
  parameter int               BYTE_CNT_W = 8,
  parameter logic [CRC_W-1:0] POLY_REFL  = 8'h8C
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start_i,
  input  logic                  mode_i,
  input  logic                  bit_vld_i,
  input  logic                  bit_i,
  output logic [CRC_W-1:0]      crc_o,
  output logic                  byte_done_o,
  output logic [BYTE_CNT_W-1:0] byte_cnt_o,
  output logic                  id_done_o,
  output logic                  id_match_o,
  output logic                  id_zero_o
);
  localparam int TOT_W = $clog2(ID_BITS + 1);

  sidc_mode_e       mode_q;
  logic             mode_is_id;
  logic             id_full;
  logic             take_w;
  logic             id_take_w;
  logic             byte_end_w;
  logic             last_pay_w;
  logic             last_id_w;
  logic [TOT_W-1:0] bit_total;
  logic [CRC_W-1:0] crc_nxt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= MODE_ID;
    else if (start_i) mode_q <= sidc_mode_e'(mode_i);
  end

  assign mode_is_id = (mode_q == MODE_ID);
  assign id_full    = mode_is_id && (bit_total == TOT_W'(ID_BITS));
  assign take_w     = bit_vld_i && !start_i && !id_full;
  assign id_take_w  = take_w && mode_is_id;

  sidc_crc_reg #(.POLY(POLY_REFL)) u_crc (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (start_i),
    .shift   (take_w),
    .din     (bit_i),
    .crc_q   (crc_o),
    .crc_nxt (crc_nxt)
  );

  sidc_bit_count #(.ID_BITS(ID_BITS), .CNT_W(BYTE_CNT_W)) u_cnt (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr         (start_i),
    .take        (take_w),
    .bit_total   (bit_total),
    .byte_end    (byte_end_w),
    .byte_done_q (byte_done_o),
    .byte_cnt_q  (byte_cnt_o)
  );

  sidc_id_cmp #(.ID_BITS(ID_BITS)) u_id (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (start_i),
    .take       (id_take_w),
    .din        (bit_i),
    .crc_nxt    (crc_nxt),
    .bit_total  (bit_total),
    .last_pay   (last_pay_w),
    .last_id    (last_id_w),
    .id_done_q  (id_done_o),
    .id_match_q (id_match_o),
    .id_zero_q  (id_zero_o)
  );
endmodule

// File: rtl/sidc_chk.sv
module sidc_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             start_i,
  input logic             take,
  input logic             is_id,
  input logic             last_id,
  input logic [7:0]       crc_o,
  input logic             byte_done_o,
  input logic [CNT_W-1:0] byte_cnt_o,
  input logic             id_done_o,
  input logic             id_match_o,
  input logic             id_zero_o
);
  // R1
  start_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_i |=> (crc_o == 8'h00 && byte_cnt_o == '0 && !id_done_o && !byte_done_o));

  // R10
  crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!take && !start_i) |=> $stable(crc_o));

  // R4
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_done_o && !start_i) |=> id_done_o);

  // R4
  done_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(id_done_o) |-> $past(last_id));

  // R6
  flags_agree_chk: assert property (@(posedge clk) disable iff (!rst_n)
    id_done_o |-> (id_match_o == id_zero_o));

  // R5
  match_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !id_done_o |-> (!id_match_o && !id_zero_o));

  // R9
  byte_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    byte_done_o |-> (byte_cnt_o == CNT_W'($past(byte_cnt_o) + 1'b1)));

  // R7
  id_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (id_done_o && !start_i) |=> ($stable(crc_o) && $stable(byte_cnt_o) && !byte_done_o));

  // R3
  stream_no_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !is_id |-> !id_done_o);
endmodule

bind sidc_crc8_chk sidc_chk #(.CNT_W(BYTE_CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start_i     (start_i),
  .take        (take_w),
  .is_id       (mode_is_id),
  .last_id     (last_id_w),
  .crc_o       (crc_o),
  .byte_done_o (byte_done_o),
  .byte_cnt_o  (byte_cnt_o),
  .id_done_o   (id_done_o),
  .id_match_o  (id_match_o),
  .id_zero_o   (id_zero_o)
);

// File: tb/tb_sidc_crc8_chk.sv
module tb_sidc_crc8_chk;
  localparam int ID_BITS = 64;
  localparam int CNT_W   = 4;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             start = 1'b0;
  logic             mode = 1'b0;
  logic             bvld = 1'b0;
  logic             bin = 1'b0;
  logic [7:0]       crc;
  logic             byte_done;
  logic [CNT_W-1:0] byte_cnt;
  logic             id_done;
  logic             id_match;
  logic             id_zero;

  always #5 clk = ~clk;

  sidc_crc8_chk #(.ID_BITS(ID_BITS), .BYTE_CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .start_i(start), .mode_i(mode),
    .bit_vld_i(bvld), .bit_i(bin), .crc_o(crc), .byte_done_o(byte_done),
    .byte_cnt_o(byte_cnt), .id_done_o(id_done), .id_match_o(id_match),
    .id_zero_o(id_zero)
  );

  typedef struct {
    bit               is_id;
    logic [7:0]       crc;
    logic [CNT_W-1:0] cnt;
    bit               match;
    bit               zero;
  } item_t;

  item_t sb[$];
  int total = 0;
  int bad = 0;

  // bench model state
  logic [7:0]       m_crc;
  logic [7:0]       m_pay;
  logic [7:0]       m_tail;
  logic [CNT_W-1:0] m_cnt;
  int               m_bits;
  bit               m_id;

  // polynomial x^8+x^5+x^4+1, reflected: taps land on bits 7,3,2
  function automatic logic [7:0] ref_bit(logic [7:0] c, logic b);
    logic [7:0] t;
    t = {1'b0, c[7:1]};
    if (c[0] != b) t = t ^ 8'b1000_1100;
    return t;
  endfunction

  function automatic logic [7:0] ref_crc56(logic [55:0] p);
    logic [7:0] c;
    c = 8'h00;
    for (int i = 0; i < 56; i++) c = ref_bit(c, p[i]);
    return c;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: pops the scoreboard as events appear
  item_t it;
  logic  prev_done = 1'b0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (byte_done) begin
        if (sb.size() == 0) chk(1'b0, "R9 unexpected byte pulse", byte_cnt, 0);
        else begin
          it = sb.pop_front();
          chk(!it.is_id && byte_cnt == it.cnt, "R9 byte count", byte_cnt, it.cnt);
          chk(crc == it.crc, "R2 crc after byte", crc, it.crc);
        end
      end
      if (id_done && !prev_done) begin
        if (sb.size() == 0) chk(1'b0, "R4 unexpected done", id_done, 0);
        else begin
          it = sb.pop_front();
          chk(it.is_id, "R4 done at 64th bit", id_done, it.is_id);
          chk(id_match == it.match, "R5 match flag", id_match, it.match);
          chk(id_zero == it.zero, "R6 zero flag", id_zero, it.zero);
          chk(id_match == id_zero, "R6 flags agree", id_zero, id_match);
        end
      end
      prev_done = id_done;
    end
  end

  task automatic model_clear(bit md);
    m_crc = 8'h00; m_pay = 8'h00; m_tail = 8'h00; m_cnt = '0; m_bits = 0; m_id = !md;
  endtask

  task automatic do_start(bit md);
    @(posedge clk); #1 start = 1'b1; mode = md; bvld = 1'b0;
    @(posedge clk); #1 start = 1'b0;
    model_clear(md);
  endtask

  task automatic send_bit(logic b, int gap);
    item_t n;
    if (!(m_id && m_bits >= ID_BITS)) begin
      m_crc = ref_bit(m_crc, b);
      m_bits++;
      if (m_bits == ID_BITS - 8) m_pay = m_crc;
      if (m_bits > ID_BITS - 8) m_tail = {b, m_tail[7:1]};
      if (m_bits % 8 == 0) begin
        m_cnt++;
        n = '{1'b0, m_crc, m_cnt, 1'b0, 1'b0};
        sb.push_back(n);
      end
      if (m_id && m_bits == ID_BITS) begin
        n = '{1'b1, 8'h00, '0, (m_pay == m_tail), (m_crc == 8'h00)};
        sb.push_back(n);
      end
    end
    @(posedge clk); #1 bvld = 1'b1; bin = b;
    if (gap > 0) begin
      @(posedge clk); #1 bvld = 1'b0;
      repeat (gap - 1) @(posedge clk);
    end
  endtask

  task automatic idle(int n);
    @(posedge clk); #1 bvld = 1'b0;
    repeat (n) @(posedge clk);
  endtask

  task automatic send_byte(logic [7:0] v, int gap);
    for (int i = 0; i < 8; i++) send_bit(v[i], gap);
  endtask

  task automatic send_id(logic [63:0] rom, int gap);
    for (int i = 0; i < 64; i++) send_bit(rom[i], gap);
  endtask

  logic [55:0] pay;
  logic [63:0] rom;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(crc == 8'h00 && byte_cnt == '0, "R1 reset crc/count", {crc, 4'(byte_cnt)}, 0);
    chk(!id_done && !id_match && !id_zero && !byte_done, "R1 reset flags",
        {id_done, id_match, id_zero, byte_done}, 0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R2 known value, stream mode
    do_start(1'b1);
    send_byte(8'h01, 0);
    idle(2);
    chk(crc == 8'h5E, "R2 crc of 0x01", crc, 8'h5E);

    // R10 gaps and idle hold
    send_byte(8'hA5, 1); send_byte(8'h3C, 2); send_byte(8'hFF, 0); send_byte(8'h00, 1);
    idle(4);
    chk(crc == m_crc, "R10 crc held over idle", crc, m_crc);

    // R9 wrap of the 4-bit counter
    for (int k = 0; k < 14; k++) send_byte(8'(k * 37 + 11), 0);
    idle(2);
    chk(byte_cnt == m_cnt, "R9 count after wrap", byte_cnt, m_cnt);

    // R3 mode input ignored between starts
    mode = 1'b0;
    for (int k = 0; k < 9; k++) send_byte(8'(k * 53 + 7), 0);
    idle(2);
    chk(!id_done, "R3 stream run raises no done", id_done, 0);
    chk(crc == m_crc, "R8 running crc in stream", crc, m_crc);

    // R5/R6/R8 well-formed identifier
    pay = 56'h00_0000_01B8_1C02;
    rom = {ref_crc56(pay), pay};
    do_start(1'b0);
    send_id(rom, 0);
    idle(2);
    chk(id_done && id_match && id_zero, "R5 good identifier", {id_done, id_match, id_zero}, 3'b111);
    chk(crc == 8'h00, "R8 residue zero", crc, 0);

    // R7 bits past the 64th
    send_byte(8'h77, 0);
    idle(2);
    chk(crc == 8'h00 && byte_cnt == 4'd8, "R7 extra bits ignored", {crc, 4'(byte_cnt)}, 12'h008);
    chk(id_done && id_match, "R7 flags kept", {id_done, id_match}, 2'b11);

    // R5 corrupted payload, slow bits
    pay = 56'h5A_C3E1_0F77_2B9D;
    rom = {ref_crc56(pay), pay};
    rom[10] = ~rom[10];
    do_start(1'b0);
    send_id(rom, 2);
    idle(2);
    chk(id_done && !id_match && !id_zero, "R5 payload error", {id_done, id_match, id_zero}, 3'b100);

    // R5 corrupted stored byte
    rom = {ref_crc56(pay), pay};
    rom[60] = ~rom[60];
    do_start(1'b0);
    send_id(rom, 0);
    idle(2);
    chk(id_done && !id_match, "R5 stored byte error", {id_done, id_match}, 2'b10);

    // R1 start beats a simultaneous bit
    do_start(1'b1);
    send_bit(1'b1, 0); send_bit(1'b0, 0); send_bit(1'b1, 0);
    @(posedge clk); #1 start = 1'b1; bvld = 1'b1; bin = 1'b1;
    @(posedge clk); #1 start = 1'b0; bvld = 1'b0;
    model_clear(1'b1);
    @(negedge clk);
    chk(crc == 8'h00 && byte_cnt == '0 && !id_done, "R1 start clears, bit dropped",
        {crc, 4'(byte_cnt)}, 0);

    idle(5);
    chk(sb.size() == 0, "R9 all expected events seen", sb.size(), 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule